// File: doc/BRIEF.md
# Per-Processor Interrupt Mask and Acknowledge Slice

This block is the private, per-processor part of a multiprocessor interrupt controller. For every interrupt source it keeps one mask bit that belongs to this processor alone. Software changes a single mask bit by writing a source number to one of two index-write registers: one masks the named source and the other unmasks it. No bitmap write is needed, so no read-modify-write is needed either.

The block combines its own mask with the per-source pending lines and with the shared enable and routing vectors. It drives a processor interrupt request and answers reads of an acknowledge register. That register names the lowest-numbered eligible source, or a reserved value when nothing is eligible. A source is eligible when it is pending, routed to this processor, globally enabled and not masked here. Two fixed per-processor sources skip the global enable term. Source 0 summarises the inter-processor doorbells and source 1 the message-signalled doorbells. To this slice they are ordinary sources.

Top module: `pcpu_irq_slice`

## Requirements
- R1: After reset every mask bit is set. With all sources pending, enabled and routed here, the acknowledge read returns 1023 and `cpu_irq` stays low.
- R2: A bus write of source number N (in `bus_wdata`) to offset 0x48 masks source N for this processor from the next cycle on. No other mask bit changes.
- R3: A bus write of source number N to offset 0x4C unmasks source N from the next cycle on. No other mask bit changes.
- R4: A mask or unmask write whose data is NUM_SRC or larger leaves every mask bit unchanged.
- R5: A read of offset 0x44 returns, one cycle later on `bus_rdata`, the number of the lowest-numbered eligible source in bits [9:0], with bits [31:10] zero.
- R6: When no source is eligible, the acknowledge read returns 1023 in bits [9:0].
- R7: A source is eligible only if its pending line is high, its routing bit for this processor (bit N*NUM_CPU+CPU_ID of `src_route`) is set, its mask bit is clear and, for shared sources, its global enable bit is set.
- R8: Sources PCPU_A and PCPU_B (3 and 5 by default) are eligible with their global enable bit low.
- R9: Reading the acknowledge register has no side effect. A second read with unchanged inputs returns the same value, and the mask is unchanged.
- R10: `cpu_irq` is high in the cycle after any source is eligible, and low in the cycle after none is.
- R11: Writes to offsets other than 0x48 and 0x4C, including 0x44, do not change any mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | NUM_SRC | Level pending line per source |
| src_gen_en | input | NUM_SRC | Global enable per source, from the shared part |
| src_route | input | NUM_SRC*NUM_CPU | Per-source processor routing masks, NUM_CPU bits per source |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the per-processor region |
| bus_wdata | input | DATA_W | Write data: a source number for the mask registers |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read and held until the next read |
| cpu_irq | output | 1 | Interrupt request to this processor |

## Verification
The bench builds the slice with NUM_SRC=16, NUM_CPU=4 and CPU_ID=2. Sixteen sources put the top source (15) and the first out-of-range numbers (16 and 1023) in reach of short directed writes. A processor index of 2 makes the routing select pick a middle bit of each source's routing field, so a slice that reads the wrong bit sees a different result. The default per-processor sources 3 and 5 are kept, so the global-enable bypass is tested next to an ordinary shared source.

// File: rtl/pcpu_irq_pkg.sv
package pcpu_irq_pkg;

    localparam int ACK_W = 10;
    localparam logic [ACK_W-1:0] ACK_NONE = '1;

    localparam int REG_ADDR_W = 12;
    localparam logic [REG_ADDR_W-1:0] OFS_ACK  = 12'h044;
    localparam logic [REG_ADDR_W-1:0] OFS_MSET = 12'h048;
    localparam logic [REG_ADDR_W-1:0] OFS_MCLR = 12'h04C;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_MASK_SET,
        OP_MASK_CLR,
        OP_ACK_RD
    } bus_op_e;

endpackage

// File: rtl/pcpu_mask_bank.sv
module pcpu_mask_bank
    import pcpu_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_op_e            op,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] mask_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;
    logic in_range;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_range = (wdata < DATA_W'(NUM_SRC));
        idx      = wdata[IDX_W-1:0];
        bank_d   = bank_q;
        if (in_range) begin
            if (op == OP_MASK_SET) begin
                bank_d.mask[idx] = 1'b1;
            end else if (op == OP_MASK_CLR) begin
                bank_d.mask[idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.mask <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask_o = bank_q.mask;

endmodule

// File: rtl/pcpu_eligible.sv
module pcpu_eligible #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int CPU_ID  = 0,
    parameter int PCPU_A  = 3,
    parameter int PCPU_B  = 5
) (
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC-1:0]         gen_en,
    input  logic [NUM_SRC*NUM_CPU-1:0] route,
    input  logic [NUM_SRC-1:0]         mask,
    output logic [NUM_SRC-1:0]         elig
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam bit IS_PCPU = (i == PCPU_A) || (i == PCPU_B);
        logic en_ok;
        if (IS_PCPU) begin : g_pcpu
            assign en_ok = 1'b1;
        end else begin : g_shared
            assign en_ok = gen_en[i];
        end
        assign elig[i] = pend[i] & route[i*NUM_CPU + CPU_ID] & en_ok & ~mask[i];
    end

endmodule

// File: rtl/pcpu_low_pick.sv
module pcpu_low_pick
    import pcpu_irq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [ACK_W-1:0]   id
);
    always_comb begin
        found = 1'b0;
        id    = ACK_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                id    = ACK_W'(i);
            end
        end
    end

endmodule

// File: rtl/pcpu_irq_slice.sv
module pcpu_irq_slice
    import pcpu_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int CPU_ID  = 0,
    parameter int PCPU_A  = 3,
    parameter int PCPU_B  = 5,
    parameter int ADDR_W  = REG_ADDR_W,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_pend,
    input  logic [NUM_SRC-1:0]         src_gen_en,
    input  logic [NUM_SRC*NUM_CPU-1:0] src_route,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       cpu_irq
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } out_t;

    out_t    out_d, out_q;
    bus_op_e op;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] elig_w;
    logic               any_w;
    logic [ACK_W-1:0]   ack_id_w;

    always_comb begin
        op = OP_IDLE;
        if (bus_valid) begin
            if (bus_write && bus_addr == ADDR_W'(OFS_MSET)) begin
                op = OP_MASK_SET;
            end else if (bus_write && bus_addr == ADDR_W'(OFS_MCLR)) begin
                op = OP_MASK_CLR;
            end else if (!bus_write && bus_addr == ADDR_W'(OFS_ACK)) begin
                op = OP_ACK_RD;
            end
        end
    end

    pcpu_mask_bank #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wdata  (bus_wdata),
        .mask_o (mask_q)
    );

    pcpu_eligible #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .CPU_ID  (CPU_ID),
        .PCPU_A  (PCPU_A),
        .PCPU_B  (PCPU_B)
    ) u_elig (
        .pend   (src_pend),
        .gen_en (src_gen_en),
        .route  (src_route),
        .mask   (mask_q),
        .elig   (elig_w)
    );

    pcpu_low_pick #(
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .req   (elig_w),
        .found (any_w),
        .id    (ack_id_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = any_w;
        if (op == OP_ACK_RD) begin
            out_d.rdata = DATA_W'(ack_id_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.rdata <= '0;
            out_q.irq   <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bus_rdata = out_q.rdata;
    assign cpu_irq   = out_q.irq;

endmodule

// File: rtl/pcpu_irq_slice_chk.sv
module pcpu_irq_slice_chk
    import pcpu_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = REG_ADDR_W,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               cpu_irq,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] elig_w
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic set_ok, clr_ok, oor_wr, other_wr, ack_rd;
    assign set_ok   = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_MSET)
                      && bus_wdata < DATA_W'(NUM_SRC);
    assign clr_ok   = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_MCLR)
                      && bus_wdata < DATA_W'(NUM_SRC);
    assign oor_wr   = bus_valid && bus_write && bus_wdata >= DATA_W'(NUM_SRC);
    assign other_wr = bus_valid && bus_write && bus_addr != ADDR_W'(OFS_MSET)
                      && bus_addr != ADDR_W'(OFS_MCLR);
    assign ack_rd   = bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_ACK);

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_ok |=> mask_q[$past(bus_wdata[IDX_W-1:0])]);

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok |=> !mask_q[$past(bus_wdata[IDX_W-1:0])]);

    p_oor_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oor_wr |=> $stable(mask_q));

    p_ack_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> bus_rdata[DATA_W-1:ACK_W] == '0);

    p_ack_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && elig_w == '0) |=> bus_rdata[ACK_W-1:0] == ACK_NONE);

    p_read_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> $stable(mask_q));

    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_w != '0) |=> cpu_irq);

    p_irq_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_w == '0) |=> !cpu_irq);

    p_other_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> $stable(mask_q));

endmodule

bind pcpu_irq_slice pcpu_irq_slice_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .mask_q    (mask_q),
    .elig_w    (elig_w)
);

// File: tb/pcpu_irq_slice_tb_top.sv
`timescale 1ns/1ps
module pcpu_irq_slice_tb_top;
    localparam int NS   = 16;
    localparam int NC   = 4;
    localparam int CID  = 2;
    localparam int AW   = 12;
    localparam int DW   = 32;
    localparam logic [AW-1:0] A_ACK = 12'h044;
    localparam logic [AW-1:0] A_SET = 12'h048;
    localparam logic [AW-1:0] A_CLR = 12'h04C;
    localparam logic [DW-1:0] NONE  = 32'd1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    src_pend = '0;
    logic [NS-1:0]    src_gen_en = '0;
    logic [NS*NC-1:0] src_route = '0;
    logic bus_valid = 1'b0;
    logic bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic cpu_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pcpu_irq_slice #(
        .NUM_SRC (NS), .NUM_CPU (NC), .CPU_ID (CID),
        .PCPU_A (3), .PCPU_B (5), .ADDR_W (AW), .DATA_W (DW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .src_pend (src_pend), .src_gen_en (src_gen_en), .src_route (src_route),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .cpu_irq (cpu_irq)
    );

    function automatic logic [NS*NC-1:0] route_for(input logic [NS-1:0] srcs, input int cpu);
        logic [NS*NC-1:0] r = '0;
        for (int i = 0; i < NS; i++) r[i*NC + cpu] = srcs[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_pend = '0; src_gen_en = '0; src_route = '0;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic read_ack(output logic [DW-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = A_ACK;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic irq_after(output logic v);
        @(negedge clk);
        @(negedge clk);
        v = cpu_irq;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d; logic v;
        do_reset();
        src_pend = '1; src_gen_en = '1; src_route = '1;
        read_ack(d);
        check("R1 all masked ack", d, NONE);
        irq_after(v);
        check("R1 irq low", {31'd0, v}, 32'd0);
    endtask

    task automatic t_unmask_lowest();
        logic [DW-1:0] d; logic v;
        do_reset();
        src_pend = 16'h0290; src_gen_en = '1; src_route = route_for('1, CID);
        bus_wr(A_CLR, 32'd9);
        read_ack(d);
        check("R3 unmask 9", d, 32'd9);
        bus_wr(A_CLR, 32'd4);
        read_ack(d);
        check("R5 lowest of 4,9", d, 32'd4);
        check("R5 upper zero", {d[31:10], 10'd0}, 32'd0);
        irq_after(v);
        check("R10 irq high", {31'd0, v}, 32'd1);
    endtask

    task automatic t_mask_again();
        logic [DW-1:0] d; logic v;
        do_reset();
        src_pend = 16'h0210; src_gen_en = '1; src_route = route_for('1, CID);
        bus_wr(A_CLR, 32'd4);
        bus_wr(A_CLR, 32'd9);
        bus_wr(A_SET, 32'd4);
        read_ack(d);
        check("R2 mask 4 leaves 9", d, 32'd9);
        bus_wr(A_SET, 32'd9);
        read_ack(d);
        check("R6 none after mask", d, NONE);
        irq_after(v);
        check("R10 irq low", {31'd0, v}, 32'd0);
    endtask

    task automatic t_routing();
        logic [DW-1:0] d;
        do_reset();
        src_pend = 16'h0100; src_gen_en = '1;
        src_route = route_for(16'h0100, 1) | route_for(16'h0100, 3);
        bus_wr(A_CLR, 32'd8);
        read_ack(d);
        check("R7 routed elsewhere", d, NONE);
        src_route = route_for(16'h0100, CID);
        read_ack(d);
        check("R7 routed here", d, 32'd8);
        src_pend = '0;
        read_ack(d);
        check("R7 not pending", d, NONE);
    endtask

    task automatic t_global_enable();
        logic [DW-1:0] d;
        do_reset();
        src_pend = 16'h0068; src_gen_en = '0; src_route = route_for('1, CID);
        bus_wr(A_CLR, 32'd6);
        read_ack(d);
        check("R7 shared disabled", d, NONE);
        bus_wr(A_CLR, 32'd5);
        read_ack(d);
        check("R8 percpu 5 bypass", d, 32'd5);
        bus_wr(A_CLR, 32'd3);
        read_ack(d);
        check("R8 percpu 3 bypass", d, 32'd3);
        src_gen_en = 16'h0040; src_pend = 16'h0040;
        read_ack(d);
        check("R7 shared enabled", d, 32'd6);
    endtask

    task automatic t_out_of_range();
        logic [DW-1:0] d;
        do_reset();
        src_pend = 16'h8000; src_gen_en = '1; src_route = route_for('1, CID);
        bus_wr(A_CLR, 32'd16);
        bus_wr(A_CLR, 32'd1023);
        bus_wr(A_CLR, 32'h0001_000F);
        read_ack(d);
        check("R4 oob clear ignored", d, NONE);
        bus_wr(A_CLR, 32'd15);
        read_ack(d);
        check("R3 top source 15", d, 32'd15);
        bus_wr(A_SET, 32'd31);
        bus_wr(A_SET, 32'h0000_010F);
        read_ack(d);
        check("R4 oob set ignored", d, 32'd15);
    endtask

    task automatic t_other_offsets();
        logic [DW-1:0] d;
        do_reset();
        src_pend = 16'h0005; src_gen_en = '1; src_route = route_for('1, CID);
        bus_wr(A_ACK, 32'd0);
        bus_wr(12'h040, 32'd0);
        bus_wr(12'h148, 32'd0);
        read_ack(d);
        check("R11 other writes ignored", d, NONE);
        bus_wr(A_CLR, 32'd2);
        bus_wr(A_CLR, 32'd0);
        bus_wr(12'h04C | 12'h100, 32'd0);
        bus_wr(A_ACK, 32'd2);
        read_ack(d);
        check("R11 source 0 first", d, 32'd0);
    endtask

    task automatic t_reread();
        logic [DW-1:0] d1, d2;
        do_reset();
        src_pend = 16'h0002; src_gen_en = '1; src_route = route_for('1, CID);
        bus_wr(A_CLR, 32'd1);
        read_ack(d1);
        read_ack(d2);
        check("R9 first read", d1, 32'd1);
        check("R9 second read same", d2, 32'd1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_unmask_lowest();
        t_mask_again();
        t_routing();
        t_global_enable();
        t_out_of_range();
        t_other_offsets();
        t_reread();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule